// File: doc/BRIEF.md
# I2C Target Address Match and Acknowledge Controller

This block is the target side of an I2C port. It watches the bus clock and data lines, finds Start and Stop conditions, and shifts in each byte. It compares the first byte after a Start with a software-loaded address in either 7-bit or 10-bit form, and then decides whether to acknowledge. While it waits on software it holds the bus clock low. SCL and SDA are synchronized to the system clock inside the block. The block drives the bus only through two pull-low enables, which suit an open-drain pad.

Software owns an 8-bit address register. In 10-bit mode the register is loaded twice. First it holds the two high address bits in bit positions 2 and 1. After the high byte is acknowledged, software writes the full low address byte. After the low byte, software writes the high bits back. Each write is marked by a strobe. Two optional hold enables pause the bus at the acknowledge slot so that software can choose the acknowledge level itself. A buffer-full flag and an overflow flag supplied by software force a not-acknowledge. Transmit data in read state and address masking are handled elsewhere.

Top module: `i2c_tgt_ctl`

## Requirements
- R1: After reset, both pull-low outputs and the flags `irq_o`, `upd_addr_o`, `ack_time_o`, `ack_stat_o` and `rd_act_o` are 0.
- R2: In 7-bit mode (`mode10_i`=0), a first byte whose bits [7:1] equal `addr_reg_i[7:1]` is acknowledged by pulling SDA low in the ninth clock pulse. Bit 0 (R/W) is ignored for matching. The byte is loaded into `rx_byte_o`, and `irq_o` is set. If bit 0 is 1, `rd_act_o` goes to 1 once the acknowledge slot has ended.
- R3: A 7-bit first byte that does not match gets no acknowledge and leaves `irq_o` at 0. Later bytes up to the next Start also get no acknowledge.
- R4: After a write match, each data byte is acknowledged and loaded into `rx_byte_o`, and `irq_o` is set. `ack_stat_o` takes the SDA level sampled in the ninth pulse, so 0 means acknowledged.
- R5: If `buf_full_i` or `ovf_i` is 1 when a byte completes, that byte gets no acknowledge, and `ack_stat_o` becomes 1.
- R6: If the hold enable for the byte type is 1 (`addr_hold_en_i` for address bytes, `data_hold_en_i` for data bytes), then at the eighth falling SCL edge `ack_time_o` is set and SCL is held low until `hold_rel_i` pulses. In that case the acknowledge level is taken from `sw_nack_i` (1 = no acknowledge). With both hold enables at 0, `ack_time_o` stays 0.
- R7: In 10-bit mode, the first byte must equal 1,1,1,1,0,`addr_reg_i[2]`,`addr_reg_i[1]`,0 (bit 7 first) to be acknowledged. After its acknowledge slot, `upd_addr_o` is set and SCL is held low until the `addr_wr_i` strobe, which clears `upd_addr_o`.
- R8: The 10-bit low byte is compared with all 8 bits of `addr_reg_i`. It is acknowledged only if it matches. In both cases `irq_o` is set, `upd_addr_o` is set, and SCL is held low after the acknowledge slot until `addr_wr_i`.
- R9: In 10-bit mode, a high byte with R/W=1 is acknowledged, and `rd_act_o` is set, only if a full high-plus-low write match has happened since the last Stop. Otherwise it gets no acknowledge. A Stop clears `rd_act_o`.
- R10: With `ss_irq_en_i`=1, every Start, repeated Start and Stop sets `irq_o`. With it at 0, these conditions alone leave `irq_o` at 0.
- R11: A pulse on `irq_clr_i` clears `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| addr_reg_i | input | 8 | Software address register |
| addr_wr_i | input | 1 | Strobe: address register rewritten |
| mode10_i | input | 1 | 1 = 10-bit addressing |
| ss_irq_en_i | input | 1 | Interrupt on Start/Stop |
| addr_hold_en_i | input | 1 | Hold for software at address acknowledge |
| data_hold_en_i | input | 1 | Hold for software at data acknowledge |
| sw_nack_i | input | 1 | Software acknowledge value, 1 = no acknowledge |
| hold_rel_i | input | 1 | Strobe: end a hold stretch |
| buf_full_i | input | 1 | Receive buffer still full |
| ovf_i | input | 1 | Overflow flag set |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| irq_o | output | 1 | Interrupt flag |
| rx_byte_o | output | 8 | Last byte received |
| upd_addr_o | output | 1 | Software must reload the address register |
| ack_time_o | output | 1 | Acknowledge-time flag in hold mode |
| ack_stat_o | output | 1 | SDA level sampled in the ninth pulse |
| rd_act_o | output | 1 | Target addressed for read |

## Verification
The checker assumes three things about the inputs:
- Software does not change the hold enables while an acknowledge slot is pending.
- The bus master never drives SCL high against a stretch.
- A bus half-period is much longer than the three-cycle synchronizer delay.

The bench meets these conditions through a bus master model:
- It joins its own lines to the pull-low outputs as a wired AND.
- It waits for SCL to read high before timing the high phase.
- It uses a half-period of 20 system clocks.
- It changes mode, enable and address inputs only between transactions or while the block holds SCL low.

// File: rtl/i2c_tgt_ctl.sv
`timescale 1ns/1ps
module i2c_tgt_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  input  logic [7:0] addr_reg_i,
  input  logic       addr_wr_i,
  input  logic       mode10_i,
  input  logic       ss_irq_en_i,
  input  logic       addr_hold_en_i,
  input  logic       data_hold_en_i,
  input  logic       sw_nack_i,
  input  logic       hold_rel_i,
  input  logic       buf_full_i,
  input  logic       ovf_i,
  input  logic       irq_clr_i,
  output logic       irq_o,
  output logic [7:0] rx_byte_o,
  output logic       upd_addr_o,
  output logic       ack_time_o,
  output logic       ack_stat_o,
  output logic       rd_act_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_ADR1, ST_ADR2, ST_WR, ST_RD} st_t;

  st_t        st, st_nx_r, nx;
  logic       scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       in_ack, ack_ok, use_sw, hold_st, upd_hold, upd_pend, full10;
  logic       take, ok, need_upd, need_hold, m7, hi10, lo10, blk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_m, scl_s, scl_q, sda_m, sda_s, sda_q} <= 6'h3f;
    else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_q <= sda_s;
    end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  assign blk  = buf_full_i | ovf_i;
  assign m7   = sh[7:1] == addr_reg_i[7:1];
  assign hi10 = (sh[7:3] == 5'b11110) && (sh[2:1] == addr_reg_i[2:1]);
  assign lo10 = sh == addr_reg_i;

  always_comb begin
    take = 1'b0; ok = 1'b0; nx = ST_IDLE; need_upd = 1'b0; need_hold = 1'b0;
    case (st)
      ST_ADR1:
        if (!mode10_i) begin
          if (m7) begin
            take = 1'b1; ok = 1'b1; need_hold = addr_hold_en_i;
            nx = sh[0] ? ST_RD : ST_WR;
          end
        end else if (hi10 && !sh[0]) begin
          take = 1'b1; ok = 1'b1; nx = ST_ADR2; need_upd = 1'b1; need_hold = addr_hold_en_i;
        end else if (hi10 && full10) begin
          take = 1'b1; ok = 1'b1; nx = ST_RD; need_hold = addr_hold_en_i;
        end
      ST_ADR2: begin
        take = 1'b1; ok = lo10; nx = lo10 ? ST_WR : ST_IDLE;
        need_upd = 1'b1; need_hold = addr_hold_en_i;
      end
      ST_WR: begin
        take = 1'b1; ok = 1'b1; nx = ST_WR; need_hold = data_hold_en_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; st_nx_r <= ST_IDLE; sh <= '0; cnt <= '0;
      in_ack <= 1'b0; ack_ok <= 1'b0; use_sw <= 1'b0; hold_st <= 1'b0;
      upd_hold <= 1'b0; upd_pend <= 1'b0; full10 <= 1'b0;
      irq_o <= 1'b0; rx_byte_o <= '0; upd_addr_o <= 1'b0;
      ack_time_o <= 1'b0; ack_stat_o <= 1'b0;
    end else begin
      if (irq_clr_i) irq_o <= 1'b0;
      if (hold_rel_i) hold_st <= 1'b0;
      if (start_c || stop_c) begin
        st <= start_c ? ST_ADR1 : ST_IDLE;
        cnt <= '0; in_ack <= 1'b0; ack_time_o <= 1'b0; hold_st <= 1'b0;
        if (stop_c) full10 <= 1'b0;
        if (ss_irq_en_i) irq_o <= 1'b1;
      end else if (st != ST_IDLE && st != ST_RD) begin
        if (scl_rise) begin
          if (in_ack) ack_stat_o <= sda_s;
          else if (cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0; ack_time_o <= 1'b0; cnt <= '0; st <= st_nx_r;
            upd_pend <= 1'b0;
            if (upd_pend) begin upd_addr_o <= 1'b1; upd_hold <= 1'b1; end
          end else if (cnt == 4'd8) begin
            if (take) begin
              rx_byte_o <= sh; irq_o <= 1'b1; in_ack <= 1'b1;
              ack_ok <= ok & ~blk; use_sw <= need_hold;
              ack_time_o <= need_hold; hold_st <= need_hold;
              upd_pend <= need_upd; st_nx_r <= nx;
              if (st == ST_ADR2) full10 <= lo10;
              else if (need_upd) full10 <= 1'b0;
            end else begin
              st <= ST_IDLE; cnt <= '0;
            end
          end
        end
      end
      if (addr_wr_i) begin upd_addr_o <= 1'b0; upd_hold <= 1'b0; end
    end

  assign sda_low_o = in_ack & ack_ok & (~use_sw | ~sw_nack_i);
  assign scl_low_o = hold_st | upd_hold;
  assign rd_act_o  = st == ST_RD;
endmodule

module i2c_tgt_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic in_ack,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic upd_addr_o,
  input logic addr_wr_i,
  input logic ack_time_o,
  input logic addr_hold_en_i,
  input logic data_hold_en_i,
  input logic buf_full_i,
  input logic ovf_i
);
  // R2
  sda_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_o |-> in_ack);
  // R5
  blocked_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_ack) && $past(buf_full_i || ovf_i)) |-> !sda_low_o);
  // R6
  ack_time_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_time_o |-> (addr_hold_en_i || data_hold_en_i));
  // R7
  upd_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_addr_o) |-> scl_low_o);
  // R7
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_addr_o && addr_wr_i) |=> !upd_addr_o);
  // R8
  stretch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low_o |-> !scl_s);
endmodule

bind i2c_tgt_ctl i2c_tgt_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .in_ack(in_ack),
  .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .upd_addr_o(upd_addr_o),
  .addr_wr_i(addr_wr_i), .ack_time_o(ack_time_o),
  .addr_hold_en_i(addr_hold_en_i), .data_hold_en_i(data_hold_en_i),
  .buf_full_i(buf_full_i), .ovf_i(ovf_i)
);

// File: tb/i2c_tgt_ctl_bench.sv
`timescale 1ns/1ps
module i2c_tgt_ctl_bench;
  localparam int HALF = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] addr_reg = 8'h00;
  logic addr_wr = 0, mode10 = 0, ss_irq_en = 0, ahold = 0, dhold = 0;
  logic sw_nack = 0, hold_rel = 0, buf_full = 0, ovf = 0, irq_clr = 0;
  logic scl_low, sda_low, irq, upd, ack_time, ack_stat, rd_act;
  logic [7:0] rx;
  logic scl_bus, sda_bus;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  assign scl_bus = m_scl & ~scl_low;
  assign sda_bus = m_sda & ~sda_low;

  i2c_tgt_ctl u_i2c_tgt_ctl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .addr_reg_i(addr_reg),
    .addr_wr_i(addr_wr), .mode10_i(mode10), .ss_irq_en_i(ss_irq_en),
    .addr_hold_en_i(ahold), .data_hold_en_i(dhold), .sw_nack_i(sw_nack),
    .hold_rel_i(hold_rel), .buf_full_i(buf_full), .ovf_i(ovf),
    .irq_clr_i(irq_clr), .irq_o(irq), .rx_byte_o(rx), .upd_addr_o(upd),
    .ack_time_o(ack_time), .ack_stat_o(ack_stat), .rd_act_o(rd_act));

  function automatic bit f_m7(input logic [7:0] b, input logic [7:0] a);
    return b[7:1] == a[7:1];
  endfunction
  function automatic logic [7:0] f_hi10(input logic [1:0] a98, input bit rw);
    return {5'b11110, a98, rw};
  endfunction
  function automatic bit f_ack(input bit match, input bit bf, input bit ov);
    return match && !bf && !ov;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask
  task automatic wait_high();
    while (!scl_bus) tick(1);
  endtask
  task automatic bus_start();
    m_sda = 0; tick(HALF); m_scl = 0; tick(HALF);
  endtask
  task automatic bus_restart();
    m_sda = 1; tick(HALF); m_scl = 1; wait_high(); tick(HALF);
    m_sda = 0; tick(HALF); m_scl = 0; tick(HALF);
  endtask
  task automatic bus_stop();
    m_sda = 0; tick(HALF); m_scl = 1; wait_high(); tick(HALF);
    m_sda = 1; tick(HALF);
  endtask
  task automatic pulse_clr();
    irq_clr = 1; tick(1); irq_clr = 0;
  endtask
  task automatic load_addr(input logic [7:0] v);
    addr_reg = v; addr_wr = 1; tick(1); addr_wr = 0; tick(4);
  endtask
  // returns SDA level sampled in the ninth pulse (0 = acknowledged)
  task automatic send_byte(input logic [7:0] b, input bit hold, input bit nack_v,
                           output bit ackbit);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(HALF); m_scl = 1; wait_high(); tick(HALF);
      m_scl = 0; tick(HALF);
    end
    m_sda = 1;
    if (hold) begin
      check("R6 ack_time", ack_time, 1);
      check("R6 stretch", scl_low, 1);
      sw_nack = nack_v; tick(50);
      check("R6 stretch held", scl_low, 1);
      hold_rel = 1; tick(1); hold_rel = 0;
    end
    tick(HALF); m_scl = 1; wait_high(); tick(HALF/2);
    ackbit = sda_bus; tick(HALF/2); m_scl = 0; tick(HALF);
  endtask

  initial begin
    bit a;
    void'($urandom(32'd7741));
    tick(5);
    check("R1 scl_low", scl_low, 0); check("R1 sda_low", sda_low, 0);
    check("R1 irq", irq, 0); check("R1 upd", upd, 0);
    check("R1 ack_time", ack_time, 0); check("R1 ack_stat", ack_stat, 0);
    check("R1 rd_act", rd_act, 0);
    rst_n = 1; tick(5);

    addr_reg = 8'hA4;
    bus_start(); send_byte(8'hA4, 0, 0, a);
    check("R2 ack", a, 0); check("R2 irq", irq, 1); check("R2 rx", rx, 8'hA4);
    check("R6 no hold flag", ack_time, 0);
    pulse_clr(); check("R11 irq clr", irq, 0);
    send_byte(8'h3C, 0, 0, a);
    check("R4 ack", a, 0); check("R4 rx", rx, 8'h3C); check("R4 ack_stat", ack_stat, 0);
    check("R4 irq", irq, 1);
    buf_full = 1; send_byte(8'h55, 0, 0, a); buf_full = 0;
    check("R5 bf nack", a, 1); check("R5 ack_stat", ack_stat, 1);
    ovf = 1; send_byte(8'h56, 0, 0, a); ovf = 0;
    check("R5 ovf nack", a, 1);
    bus_stop();
    bus_start(); send_byte(8'hA5, 0, 0, a);
    check("R2 rw ignored", a, 0); check("R2 read", rd_act, 1);
    bus_stop(); check("R9 stop clears read", rd_act, 0);

    for (int it = 0; it < 16; it++) begin
      logic [7:0] own, b, d;
      bit m, bf, ov;
      own = 8'($urandom);
      b = ($urandom % 2) ? {own[7:1], 1'($urandom)} : 8'($urandom);
      m = f_m7(b, own);
      addr_reg = own; pulse_clr();
      bus_start(); send_byte(b, 0, 0, a);
      check(m ? "R2 rand ack" : "R3 rand nack", a, m ? 0 : 1);
      check(m ? "R2 rand irq" : "R3 rand irq", irq, m ? 1 : 0);
      for (int k = 0; k < 2; k++) begin
        if (m && b[0]) break;
        d = 8'($urandom); bf = ($urandom % 4) == 0; ov = ($urandom % 4) == 1;
        buf_full = bf; ovf = ov;
        send_byte(d, 0, 0, a);
        buf_full = 0; ovf = 0;
        if (m) begin
          check(bf || ov ? "R5 rand data" : "R4 rand data", a, f_ack(1, bf, ov) ? 0 : 1);
          check("R4 rand rx", rx, d);
        end else check("R3 later byte", a, 1);
      end
      bus_stop();
    end

    ahold = 1; dhold = 1; addr_reg = 8'hA4;
    bus_start(); send_byte(8'hA4, 1, 0, a);
    check("R6 sw ack", a, 0);
    send_byte(8'h11, 1, 1, a);
    check("R6 sw nack", a, 1); check("R6 flag cleared", ack_time, 0);
    bus_stop(); ahold = 0; dhold = 0; sw_nack = 0;

    mode10 = 1; addr_reg = 8'h04;
    bus_start(); send_byte(f_hi10(2'b10, 0), 0, 0, a);
    check("R7 high ack", a, 0); check("R7 upd", upd, 1); check("R7 stretch", scl_low, 1);
    tick(40); check("R7 still held", scl_low, 1);
    load_addr(8'hB7); check("R7 released", scl_low, 0); check("R7 upd clr", upd, 0);
    pulse_clr(); send_byte(8'hB7, 0, 0, a);
    check("R8 low ack", a, 0); check("R8 irq", irq, 1); check("R8 upd", upd, 1);
    check("R8 stretch", scl_low, 1);
    load_addr(8'h04); check("R8 released", scl_low, 0);
    send_byte(8'h99, 0, 0, a); check("R8 data ack", a, 0); check("R8 data rx", rx, 8'h99);
    bus_restart(); send_byte(f_hi10(2'b10, 1), 0, 0, a);
    check("R9 read ack", a, 0); check("R9 read", rd_act, 1);
    bus_stop(); check("R9 stop", rd_act, 0);
    bus_start(); send_byte(f_hi10(2'b10, 1), 0, 0, a);
    check("R9 read w/o match", a, 1); check("R9 no read", rd_act, 0);
    bus_stop();

    bus_start(); send_byte(f_hi10(2'b10, 0), 0, 0, a);
    load_addr(8'hB7); pulse_clr();
    send_byte(8'hB6, 0, 0, a);
    check("R8 low nack", a, 1); check("R8 irq mismatch", irq, 1);
    check("R8 upd mismatch", upd, 1); check("R8 stretch mismatch", scl_low, 1);
    load_addr(8'h04); check("R8 released mismatch", scl_low, 0);
    bus_restart(); send_byte(f_hi10(2'b10, 1), 0, 0, a);
    check("R9 read after bad low", a, 1);
    bus_stop();
    bus_start(); send_byte(f_hi10(2'b01, 0), 0, 0, a);
    check("R7 wrong high", a, 1);
    bus_stop(); mode10 = 0;

    ss_irq_en = 1; pulse_clr();
    bus_start(); check("R10 start irq", irq, 1);
    pulse_clr(); check("R11 clear", irq, 0);
    bus_restart(); check("R10 restart irq", irq, 1);
    pulse_clr(); bus_stop(); check("R10 stop irq", irq, 1);
    ss_irq_en = 0; pulse_clr();
    bus_start(); bus_stop(); check("R10 disabled", irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule